// File: doc/BRIEF.md
# Stack-Relative Multiply Operand Decoder

This block sits in front of a floating-point multiply datapath that works on an eight-entry register stack. Each register is addressed relative to a moving top pointer. When an issue strobe arrives, the block reads the opcode byte and the ModRM byte of a multiply instruction. It then resolves which physical registers serve as source and destination, and whether the second operand is a memory value of a given format. The block keeps the top pointer and a per-register "holds a value" tag. It checks that every register the instruction reads holds a value. If any of them is empty, it flags a stack fault instead of launching the operation.

The external datapath performs the multiplication. It then pulses a writeback strobe, together with a flag saying whether the product was rounded up. On that strobe the block marks the destination register as holding a value. For the popping form, the block then frees the old top register and advances the pointer. The write address is always taken from the pointer as it was before the pop. Only one operation is outstanding at a time.

After reset the pointer and the tags take parameter values. By default the pointer is 0 and all eight registers hold values.

Top module: `stk_mul_decode`

## Requirements
- R1: After reset, `top_o` is 0, `valid_o` is all ones, `mem_kind_o` is 0, and `pend_o`, `stk_fault_o` and `c1_o` are 0.
- R2: A memory form is one where ModRM bits 5:3 equal 1 and bits 7:6 are not 3. For such a form, `mem_kind_o` becomes 1 for opcode D8 (32-bit float), 2 for DC (64-bit float), 4 for DA (32-bit integer) and 3 for DE (16-bit integer). Both `src_idx_o` and `dst_idx_o` equal the top pointer.
- R3: Opcode D8 with ModRM C8+i gives `src_idx_o` = (top+i) mod 8, `dst_idx_o` = top, and `mem_kind_o` 0.
- R4: Opcode DC with ModRM C8+i gives `dst_idx_o` = (top+i) mod 8 and `src_idx_o` = top, with no pop.
- R5: Opcode DE with ModRM C8+i indexes like R4 and pops at writeback. DE C9 is the form that targets slot 1 and pops.
- R6: A pop happens in the writeback cycle, after the write. It clears the tag of the pre-pop top register and moves the pointer up by one, wrapping from 7 to 0. For DE C8 the register written is left empty.
- R7: If a register the accepted instruction reads is empty, `stk_fault_o` goes to 1 and `c1_o` to 0. No operation becomes pending, and the tags and the pointer are unchanged.
- R8: A writeback while `pend_o` is 1 sets the destination tag, loads `c1_o` from `wb_rnd_up_i` and clears `pend_o`.
- R9: Any opcode/ModRM pair that is not one of the forms above leaves every output unchanged.
- R10: An issue while `pend_o` is 1 is ignored. A writeback while `pend_o` is 0 is ignored.
- R11: `stk_fault_o` holds its value until the next accepted multiply issue, which reloads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | One-cycle issue strobe |
| opc_i | input | 8 | Opcode byte |
| modrm_i | input | 8 | ModRM byte |
| wb_i | input | 1 | Writeback strobe from the datapath |
| wb_rnd_up_i | input | 1 | Product was rounded up |
| src_idx_o | output | PTR_W (3) | Physical source register |
| dst_idx_o | output | PTR_W (3) | Physical destination register |
| mem_kind_o | output | 3 | Memory operand kind (0 none) |
| pend_o | output | 1 | Operation awaiting writeback |
| stk_fault_o | output | 1 | Stack underflow on last accepted issue |
| c1_o | output | 1 | Condition flag C1 |
| top_o | output | PTR_W (3) | Top-of-stack pointer |
| valid_o | output | NREG (8) | Per-register holds-a-value tags |

## Verification
The assertions check several things on every cycle. The pointer may move only by a single step and only on a popping writeback. Tags may change only at a writeback, and then in no more than two bits. An underflow freezes the tags and the pointer and leaves C1 clear. A pending operation holds its indices until writeback. Other behaviour can only be shown by the bench's scenarios, where expected values are computed from the register model. This covers the exact index arithmetic for every ModRM value under each opcode, and the memory-kind codes. It also covers the pointer wrap after a run of pops, the write-then-free order of DE C8, and the fault flag surviving an ignored encoding.

// File: rtl/smd_pkg.sv
package smd_pkg;

    typedef enum logic [2:0] {
        MK_NONE = 3'd0,
        MK_F32  = 3'd1,
        MK_F64  = 3'd2,
        MK_I16  = 3'd3,
        MK_I32  = 3'd4
    } mem_kind_e;

    localparam logic [7:0] OPC_GRP_S   = 8'hD8;
    localparam logic [7:0] OPC_GRP_D   = 8'hDC;
    localparam logic [7:0] OPC_GRP_I32 = 8'hDA;
    localparam logic [7:0] OPC_GRP_P   = 8'hDE;
    localparam logic [2:0] MUL_SUBOP   = 3'd1;
    localparam logic [1:0] MOD_DIRECT  = 2'b11;

    typedef struct packed {
        logic      hit;       // a multiply form was recognised
        logic      reg_form;  // second operand is a stack register
        logic      dst_rel;   // destination is slot i rather than slot 0
        logic      pop;       // pop after writeback
        mem_kind_e kind;
        logic [2:0] rel_idx;  // slot i from the ModRM rm field
    } dec_t;

endpackage

// File: rtl/smd_decode.sv
module smd_decode
    import smd_pkg::*;
(
    input  logic [7:0] opc_i,
    input  logic [7:0] modrm_i,
    output dec_t       dec_o
);

    logic [1:0] mod_f;
    logic [2:0] sub_f;

    assign mod_f = modrm_i[7:6];
    assign sub_f = modrm_i[5:3];

    always_comb begin
        dec_o          = '0;
        dec_o.kind     = MK_NONE;
        dec_o.rel_idx  = modrm_i[2:0];
        if (sub_f == MUL_SUBOP) begin
            if (mod_f != MOD_DIRECT) begin
                dec_o.hit = 1'b1;
                unique case (opc_i)
                    OPC_GRP_S:   dec_o.kind = MK_F32;
                    OPC_GRP_D:   dec_o.kind = MK_F64;
                    OPC_GRP_I32: dec_o.kind = MK_I32;
                    OPC_GRP_P:   dec_o.kind = MK_I16;
                    default:     dec_o.hit  = 1'b0;
                endcase
            end else begin
                dec_o.reg_form = 1'b1;
                unique case (opc_i)
                    OPC_GRP_S: dec_o.hit = 1'b1;
                    OPC_GRP_D: begin
                        dec_o.hit     = 1'b1;
                        dec_o.dst_rel = 1'b1;
                    end
                    OPC_GRP_P: begin
                        dec_o.hit     = 1'b1;
                        dec_o.dst_rel = 1'b1;
                        dec_o.pop     = 1'b1;
                    end
                    default: dec_o.reg_form = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/smd_rel2phys.sv
module smd_rel2phys #(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] top_i,
    input  logic [2:0]       rel_i,
    output logic [PTR_W-1:0] phys_o
);

    // modulo arithmetic falls out of the pointer width
    assign phys_o = top_i + PTR_W'(rel_i);

endmodule

// File: rtl/smd_tag_probe.sv
module smd_tag_probe #(
    parameter int NREG  = 8,
    parameter int PTR_W = 3
) (
    input  logic [NREG-1:0]  valid_i,
    input  logic [PTR_W-1:0] idx_i,
    output logic             full_o
);

    assign full_o = valid_i[idx_i];

endmodule

// File: rtl/stk_mul_decode.sv
module stk_mul_decode
    import smd_pkg::*;
#(
    parameter int              NREG        = 8,
    parameter int              PTR_W       = $clog2(NREG),
    parameter int              RESET_TOP   = 0,
    parameter logic [NREG-1:0] RESET_VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [7:0]       opc_i,
    input  logic [7:0]       modrm_i,
    input  logic             wb_i,
    input  logic             wb_rnd_up_i,
    output logic [PTR_W-1:0] src_idx_o,
    output logic [PTR_W-1:0] dst_idx_o,
    output logic [2:0]       mem_kind_o,
    output logic             pend_o,
    output logic             stk_fault_o,
    output logic             c1_o,
    output logic [PTR_W-1:0] top_o,
    output logic [NREG-1:0]  valid_o
);

    localparam int NPORT = 2;   // operand slot 0 and slot i

    typedef struct packed {
        logic [PTR_W-1:0] top;
        logic [NREG-1:0]  valid;
        logic [PTR_W-1:0] src;
        logic [PTR_W-1:0] dst;
        mem_kind_e        kind;
        logic             pend;
        logic             pop;
        logic             fault;
        logic             c1;
    } state_t;

    localparam state_t ST_RST = '{
        top:   PTR_W'(RESET_TOP),
        valid: RESET_VALID,
        src:   '0,
        dst:   '0,
        kind:  MK_NONE,
        pend:  1'b0,
        pop:   1'b0,
        fault: 1'b0,
        c1:    1'b0
    };

    state_t st_q, st_d;
    dec_t   dec;

    logic [2:0]       rel_w  [NPORT];
    logic [PTR_W-1:0] phys_w [NPORT];
    logic             full_w [NPORT];

    logic issue_acc;
    logic uflow;
    logic wb_acc;

    smd_decode u_dec (
        .opc_i   (opc_i),
        .modrm_i (modrm_i),
        .dec_o   (dec)
    );

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        if (k == 0) begin : g_slot0
            assign rel_w[k] = 3'd0;
        end else begin : g_sloti
            assign rel_w[k] = dec.rel_idx;
        end

        smd_rel2phys #(.PTR_W(PTR_W)) u_map (
            .top_i  (st_q.top),
            .rel_i  (rel_w[k]),
            .phys_o (phys_w[k])
        );

        smd_tag_probe #(.NREG(NREG), .PTR_W(PTR_W)) u_probe (
            .valid_i (st_q.valid),
            .idx_i   (phys_w[k]),
            .full_o  (full_w[k])
        );
    end

    assign issue_acc = issue_i && !st_q.pend && dec.hit;
    assign wb_acc    = wb_i && st_q.pend;
    assign uflow     = !full_w[0] || (dec.reg_form && !full_w[1]);

    always_comb begin
        st_d = st_q;
        if (wb_acc) begin
            st_d.valid[st_q.dst] = 1'b1;
            if (st_q.pop) begin
                st_d.valid[st_q.top] = 1'b0;
                st_d.top             = st_q.top + PTR_W'(1);
            end
            st_d.c1   = wb_rnd_up_i;
            st_d.pend = 1'b0;
            st_d.pop  = 1'b0;
        end else if (issue_acc) begin
            st_d.kind  = dec.kind;
            st_d.src   = (dec.reg_form && !dec.dst_rel) ? phys_w[1] : phys_w[0];
            st_d.dst   = dec.dst_rel ? phys_w[1] : phys_w[0];
            st_d.fault = uflow;
            if (uflow) begin
                st_d.c1 = 1'b0;
            end else begin
                st_d.pend = 1'b1;
                st_d.pop  = dec.pop;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_idx_o   = st_q.src;
    assign dst_idx_o   = st_q.dst;
    assign mem_kind_o  = st_q.kind;
    assign pend_o      = st_q.pend;
    assign stk_fault_o = st_q.fault;
    assign c1_o        = st_q.c1;
    assign top_o       = st_q.top;
    assign valid_o     = st_q.valid;

    // underflow freezes the stack state and launches nothing
    p_uflow_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_acc && uflow) |=> (stk_fault_o && !pend_o && !c1_o
                                  && $stable(valid_o) && $stable(top_o)));

    p_fault_clears_c1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_fault_o |-> !c1_o);

    // tags move only on an accepted writeback, by at most two bits
    p_tags_need_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_i && pend_o) |=> $stable(valid_o));

    p_tag_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_o ^ $past(valid_o)) <= 2);

    // pointer moves one step, only on a popping writeback
    p_top_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_i && pend_o && st_q.pop) |=> $stable(top_o));

    p_top_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_i && pend_o && st_q.pop) |=> (top_o == $past(top_o) + PTR_W'(1)));

    // pending work is not disturbed by a new issue
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !wb_i) |=> (pend_o && $stable(src_idx_o)
                               && $stable(dst_idx_o) && $stable(mem_kind_o)));

endmodule

// File: tb/stk_mul_decode_test.sv
module stk_mul_decode_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic       wb = 1'b0;
    logic       rnd = 1'b0;
    logic [7:0] opc = 8'h00;
    logic [7:0] mrm = 8'h00;

    logic [2:0] src_idx, dst_idx, mem_kind, top;
    logic       pend, fault, c1;
    logic [7:0] valid;

    stk_mul_decode uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue),
        .opc_i       (opc),
        .modrm_i     (mrm),
        .wb_i        (wb),
        .wb_rnd_up_i (rnd),
        .src_idx_o   (src_idx),
        .dst_idx_o   (dst_idx),
        .mem_kind_o  (mem_kind),
        .pend_o      (pend),
        .stk_fault_o (fault),
        .c1_o        (c1),
        .top_o       (top),
        .valid_o     (valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench register model
    int       m_top, m_src, m_dst, m_kind;
    bit [7:0] m_val;
    bit       m_pend, m_pop, m_fault, m_c1;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "top",   int'(top),      m_top);
        chk(tag, "tags",  int'(valid),    int'(m_val));
        chk(tag, "pend",  int'(pend),     int'(m_pend));
        chk(tag, "fault", int'(fault),    int'(m_fault));
        chk(tag, "c1",    int'(c1),       int'(m_c1));
        chk(tag, "src",   int'(src_idx),  m_src);
        chk(tag, "dst",   int'(dst_idx),  m_dst);
        chk(tag, "kind",  int'(mem_kind), m_kind);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; issue = 1'b0; wb = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_top = 0; m_val = 8'hFF; m_src = 0; m_dst = 0; m_kind = 0;
        m_pend = 0; m_pop = 0; m_fault = 0; m_c1 = 0;
    endtask

    function automatic int slot(int rel);
        return (m_top + rel) % 8;
    endfunction

    task automatic do_issue(logic [7:0] op, logic [7:0] m);
        bit    mem_form, reg_form, uf;
        int    i, kind;
        string tag;
        @(negedge clk);
        opc = op; mrm = m; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        mem_form = (m[5:3] == 3'd1) && (m[7:6] != 2'b11);
        reg_form = (m[5:3] == 3'd1) && (m[7:6] == 2'b11) &&
                   (op == 8'hD8 || op == 8'hDC || op == 8'hDE);
        i = int'(m[2:0]);
        kind = (op == 8'hD8) ? 1 : (op == 8'hDC) ? 2 :
               (op == 8'hDE) ? 3 : (op == 8'hDA) ? 4 : 0;
        if (m_pend) begin
            tag = "R10";
        end else if (!(reg_form || (mem_form && kind != 0))) begin
            tag = "R9";
        end else begin
            if (mem_form) begin
                m_kind = kind; m_src = slot(0); m_dst = slot(0);
                uf = !m_val[slot(0)];
                tag = "R2";
            end else begin
                m_kind = 0;
                uf = !m_val[slot(0)] || !m_val[slot(i)];
                if (op == 8'hD8) begin
                    m_src = slot(i); m_dst = slot(0); tag = "R3";
                end else begin
                    m_src = slot(0); m_dst = slot(i);
                    tag = (op == 8'hDC) ? "R4" : "R5";
                end
            end
            m_fault = uf;
            if (uf) begin
                m_c1 = 1'b0;
                tag = "R7";
            end else begin
                m_pend = 1'b1;
                m_pop  = reg_form && (op == 8'hDE);
            end
        end
        check_all(tag);
    endtask

    task automatic do_wb(bit r);
        string tag;
        @(negedge clk);
        wb = 1'b1; rnd = r;
        @(negedge clk);
        wb = 1'b0;
        if (m_pend) begin
            m_val[m_dst] = 1'b1;
            tag = "R8";
            if (m_pop) begin
                m_val[m_top] = 1'b0;
                m_top = (m_top + 1) % 8;
                tag = "R6";
            end
            m_c1 = r; m_pend = 0; m_pop = 0;
        end else begin
            tag = "R10";
        end
        check_all(tag);
    endtask

    initial begin
        automatic logic [7:0] ops [8] = '{8'hD8, 8'hD9, 8'hDA, 8'hDB,
                                           8'hDC, 8'hDD, 8'hDE, 8'hDF};
        automatic int cnt = 0;

        reset_dut();
        check_all("R1");

        // R10: writeback with nothing pending
        do_wb(1'b1);

        // R6: seven popping forms on slot 1, then the slot-0 pop wraps the pointer
        for (int k = 0; k < 7; k++) begin
            do_issue(8'hDE, 8'hC9);
            do_wb(1'b0);
        end
        do_issue(8'hDE, 8'hC8);
        do_wb(1'b1);
        chk("R6", "wrapped top", int'(top), 0);
        chk("R6", "written then freed", int'(valid), 0);

        // R7: everything empty now
        do_issue(8'hD8, 8'h08);
        chk("R7", "fault", int'(fault), 1);
        // R9 and R11: ignored encoding keeps the fault
        do_issue(8'hD9, 8'h08);
        chk("R11", "fault held", int'(fault), 1);

        // R11: fault cleared by the next good issue; R10 busy issue ignored
        reset_dut();
        do_issue(8'hDE, 8'hC8);
        do_wb(1'b0);
        do_issue(8'hD8, 8'hCF);
        chk("R7", "slot 7 empty", int'(fault), 1);
        do_issue(8'hD8, 8'hC9);
        chk("R11", "fault cleared", int'(fault), 0);
        do_issue(8'hDC, 8'hCA);
        chk("R10", "still pending", int'(pend), 1);
        do_wb(1'b1);

        // sweep every ModRM value under eight opcodes
        foreach (ops[j]) begin
            for (int m = 0; m < 256; m++) begin
                if (cnt % 12 == 0) begin
                    reset_dut();
                    check_all("R1");
                end
                do_issue(ops[j], 8'(m));
                if (m_pend) do_wb(m[0] ^ m[3]);
                cnt++;
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule